// File: doc/BRIEF.md
# JTAG Configuration Readback Sequencer

This block is a JTAG master that runs one fixed script against a target TAP controller. It works in a single-clock model: each cycle of `clk` is one TCK period. TMS and TDI are decoded from registered state, so they are stable for the whole cycle. The target acts on them at the next rising edge, and the block samples TDO on that same edge. A pulse on `start` runs the script once. The script has these steps:

1. Wait in Run-Test/Idle.
2. Load the configuration-write instruction.
3. Shift eleven fixed 32-bit command packets into the data register.
4. Load the configuration-read instruction.
5. Clock a requested number of readback bits in from TDO.
6. Park the TAP in Test-Logic-Reset.

Readback bits are packed into 32-bit words, first bit in the MSB, with one valid strobe per word.

The sequencer is a Moore machine. It has nine named states:

| State | Meaning |
|---|---|
| `S_IDLE` | Waiting for `start` |
| `S_RTI` | Idle wait |
| `S_SEL` | Scan-select walk, TMS=1 |
| `S_CAP` | Capture/shift entry, TMS=0 |
| `S_IR` | Instruction shift |
| `S_CMD` | Packet shift |
| `S_RB` | Readback shift |
| `S_RST` | Reset walk |
| `S_DONE` | Completion pulse |

A leg register tells the shared states `S_SEL` and `S_CAP` what comes next. The transitions, in order, are:

- `S_IDLE` goes to `S_RTI` on start.
- `S_RTI` goes to `S_SEL`, which goes to `S_CAP`, which goes to `S_IR` (leg load-write).
- `S_IR` goes to `S_SEL`, then `S_CAP`, then `S_CMD` (leg packets).
- `S_CMD` goes to `S_SEL`, then `S_CAP`, then `S_IR` (leg load-read).
- `S_IR` goes to `S_SEL`, then `S_CAP`, then `S_RB` (leg read).
- `S_RB` goes to `S_SEL`, then `S_CAP`, then `S_RST` (leg park).
- `S_RST` goes to `S_DONE`, which goes back to `S_IDLE`.

Top module: `jrb_seq`

## Requirements
- R1: After reset, and whenever the block is idle: tms=1, tdi=0, busy=0, done=0 and rb_valid=0.
- R2: After start is accepted, TMS is held at 0 for exactly RTI_CYCLES (12) cycles before the first TMS=1.
- R3: Instruction loads are 10 bits, shifted LSB first. The 10th bit is shifted on the cycle that drives TMS=1. The first load is 10'b1111000101 (write) and the second is 10'b1111000100 (read).
- R4: The eleven packet words are shifted MSB first, 352 bits in all, with TMS=1 only on the last bit. The words in order are FFFFFFFF, AA995566, 20000000, 30008001, 00000004, 30002001, 00000000, 28006000, 48024090, 20000000, 20000000.
- R5: The walks between shifts are fixed:
  - 2 ones then 2 zeros after the idle wait and after each instruction shift;
  - 3 ones then 2 zeros after the packet shift and after the readback shift.

  The whole run therefore lasts 411+N cycles from the accepting edge to the cycle before done.
- R6: The readback shift lasts exactly N cycles: N-1 with TMS=0 and the last with TMS=1. TDO is captured on each of these N cycles.
- R7: Captured bits are packed first bit into bit 31. A full word gives a one-cycle rb_valid with rb_partial=0. A final word of fewer than 32 bits is left-aligned, zero-filled, and flagged with rb_partial=1. rb_valid occurs only while busy.
- R8: After the readback, the script walks through Shift-IR and then holds TMS=1 for 5 cycles, which ends in Test-Logic-Reset. done is high for exactly one cycle, in the cycle after that, and busy is low in that cycle.
- R9: busy rises only on an accepted start. A start raised while busy is ignored: the run is unchanged and no second run follows.
- R10: rb_bits is latched when start is accepted. A request of 0 is treated as 1 bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one TCK period per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Run request, accepted only when idle |
| rb_bits | input | RB_W | Number of readback bits to capture |
| busy | output | 1 | High while the script runs |
| done | output | 1 | One-cycle completion pulse |
| tms | output | 1 | Test mode select toward the target |
| tdi | output | 1 | Test data toward the target |
| tdo | input | 1 | Test data from the target, sampled each edge |
| rb_word | output | 32 | Packed readback word |
| rb_valid | output | 1 | Strobe for rb_word |
| rb_partial | output | 1 | rb_word is a left-aligned final partial word |

## Verification
A wrong state or leg shows at TMS in the very cycle it is entered. The bench's full TAP state model then walks to a different controller state, so the instruction capture, the packet count or the final Test-Logic-Reset check fails within that run. A counter that is off by one shows as a shifted packet bit, a readback length of N±1, or a total run length that differs from 411+N. A packing fault shows at the first rb_valid, as a wrong word or a wrong partial flag against words built from the known TDO pattern.

// File: rtl/jrb_pkg.sv
package jrb_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_RTI, S_SEL, S_CAP, S_IR, S_CMD, S_RB, S_RST, S_DONE
    } seq_state_t;

    // Which shift follows the next select/capture walk
    typedef enum logic [2:0] {
        LEG_LOAD_WR, LEG_PKT, LEG_LOAD_RD, LEG_READ, LEG_PARK
    } seq_leg_t;

    localparam int          IR_LEN      = 10;
    localparam logic [9:0]  INSN_CFG_WR = 10'b1111000101;
    localparam logic [9:0]  INSN_CFG_RD = 10'b1111000100;
    localparam int          PKT_WORDS   = 11;
    localparam int          PKT_BITS    = PKT_WORDS * 32;
    localparam int          PARK_ONES   = 5;

    function automatic logic [31:0] pkt_word(input logic [3:0] idx);
        unique case (idx)
            4'd0:    return 32'hFFFF_FFFF;
            4'd1:    return 32'hAA99_5566;
            4'd2:    return 32'h2000_0000;
            4'd3:    return 32'h3000_8001;
            4'd4:    return 32'h0000_0004;
            4'd5:    return 32'h3000_2001;
            4'd6:    return 32'h0000_0000;
            4'd7:    return 32'h2800_6000;
            4'd8:    return 32'h4802_4090;
            4'd9:    return 32'h2000_0000;
            4'd10:   return 32'h2000_0000;
            default: return 32'h0000_0000;
        endcase
    endfunction

endpackage

// File: rtl/jrb_cmd_src.sv
module jrb_cmd_src
    import jrb_pkg::*;
(
    input  logic [8:0] bit_idx,
    output logic       bit_o
);
    logic [31:0] word;

    always_comb begin
        word  = pkt_word(bit_idx[8:5]);
        // MSB first within each word
        bit_o = word[~bit_idx[4:0]];
    end
endmodule

// File: rtl/jrb_deser.sv
module jrb_deser #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              bit_val,
    input  logic              bit_last,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o,
    output logic              partial_o
);
    localparam int FW = $clog2(WORD_W);
    localparam logic [FW-1:0] FILL_MAX = FW'(WORD_W - 1);

    logic [FW-1:0]     fill;
    logic [WORD_W-1:0] acc;
    logic [WORD_W-1:0] shifted;

    assign shifted = {acc[WORD_W-2:0], bit_val};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill      <= '0;
            acc       <= '0;
            word_o    <= '0;
            valid_o   <= 1'b0;
            partial_o <= 1'b0;
        end else begin
            valid_o   <= 1'b0;
            partial_o <= 1'b0;
            if (bit_en) begin
                if (fill == FILL_MAX || bit_last) begin
                    word_o    <= shifted << (FILL_MAX - fill);
                    valid_o   <= 1'b1;
                    partial_o <= (fill != FILL_MAX);
                    fill      <= '0;
                    acc       <= '0;
                end else begin
                    acc  <= shifted;
                    fill <= fill + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/jrb_seq.sv
module jrb_seq
    import jrb_pkg::*;
#(
    parameter int RTI_CYCLES = 12,
    parameter int RB_W       = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [RB_W-1:0] rb_bits,
    output logic            busy,
    output logic            done,
    output logic            tms,
    output logic            tdi,
    input  logic            tdo,
    output logic [31:0]     rb_word,
    output logic            rb_valid,
    output logic            rb_partial
);
    localparam int CW_PKT = $clog2(PKT_BITS) + 1;
    localparam int CW_RTI = $clog2(RTI_CYCLES) + 1;
    localparam int CW_AB  = (RB_W > CW_PKT) ? RB_W : CW_PKT;
    localparam int CNT_W  = (CW_AB > CW_RTI) ? CW_AB : CW_RTI;

    seq_state_t      state, state_n;
    seq_leg_t        leg, leg_n;
    logic [CNT_W-1:0] cnt, cnt_n, seg_len;
    logic [RB_W-1:0] rb_len;
    logic            seg_last;
    logic            cmd_bit;
    logic            bit_en, bit_last;
    logic [9:0]      insn;

    jrb_cmd_src u_cmd (
        .bit_idx (cnt[8:0]),
        .bit_o   (cmd_bit)
    );

    jrb_deser #(.WORD_W(32)) u_deser (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .bit_val   (tdo),
        .bit_last  (bit_last),
        .word_o    (rb_word),
        .valid_o   (rb_valid),
        .partial_o (rb_partial)
    );

    // Length of the segment the current state presents
    always_comb begin
        unique case (state)
            S_RTI:   seg_len = CNT_W'(RTI_CYCLES);
            S_SEL:   seg_len = (leg == LEG_LOAD_RD || leg == LEG_PARK) ?
                               CNT_W'(3) : CNT_W'(2);
            S_CAP:   seg_len = CNT_W'(2);
            S_IR:    seg_len = CNT_W'(IR_LEN);
            S_CMD:   seg_len = CNT_W'(PKT_BITS);
            S_RB:    seg_len = CNT_W'(rb_len);
            S_RST:   seg_len = CNT_W'(PARK_ONES);
            default: seg_len = CNT_W'(1);
        endcase
        seg_last = (cnt == seg_len - 1'b1);
        insn     = (leg == LEG_LOAD_WR) ? INSN_CFG_WR : INSN_CFG_RD;
    end

    // Next state
    always_comb begin
        state_n = state;
        leg_n   = leg;
        cnt_n   = seg_last ? '0 : cnt + 1'b1;
        unique case (state)
            S_IDLE: begin
                cnt_n = '0;
                if (start) begin
                    state_n = S_RTI;
                    leg_n   = LEG_LOAD_WR;
                end
            end
            S_RTI: if (seg_last) state_n = S_SEL;
            S_SEL: if (seg_last) state_n = S_CAP;
            S_CAP: if (seg_last) begin
                unique case (leg)
                    LEG_LOAD_WR, LEG_LOAD_RD: state_n = S_IR;
                    LEG_PKT:                  state_n = S_CMD;
                    LEG_READ:                 state_n = S_RB;
                    default:                  state_n = S_RST;
                endcase
            end
            S_IR: if (seg_last) begin
                state_n = S_SEL;
                leg_n   = (leg == LEG_LOAD_WR) ? LEG_PKT : LEG_READ;
            end
            S_CMD: if (seg_last) begin
                state_n = S_SEL;
                leg_n   = LEG_LOAD_RD;
            end
            S_RB: if (seg_last) begin
                state_n = S_SEL;
                leg_n   = LEG_PARK;
            end
            S_RST:  if (seg_last) state_n = S_DONE;
            S_DONE: begin
                state_n = S_IDLE;
                cnt_n   = '0;
            end
            default: state_n = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            leg    <= LEG_LOAD_WR;
            cnt    <= '0;
            rb_len <= RB_W'(1);
        end else begin
            state <= state_n;
            leg   <= leg_n;
            cnt   <= cnt_n;
            if (state == S_IDLE && start)
                rb_len <= (rb_bits == '0) ? RB_W'(1) : rb_bits;
        end
    end

    // Outputs decoded from registered state
    always_comb begin
        tms      = 1'b1;
        tdi      = 1'b0;
        busy     = 1'b1;
        done     = 1'b0;
        bit_en   = 1'b0;
        bit_last = 1'b0;
        unique case (state)
            S_IDLE: busy = 1'b0;
            S_RTI:  tms  = 1'b0;
            S_SEL:  tms  = 1'b1;
            S_CAP:  tms  = 1'b0;
            S_IR: begin
                tms = seg_last;
                tdi = insn[cnt[3:0]];
            end
            S_CMD: begin
                tms = seg_last;
                tdi = cmd_bit;
            end
            S_RB: begin
                tms      = seg_last;
                bit_en   = 1'b1;
                bit_last = seg_last;
            end
            S_RST:  tms = 1'b1;
            S_DONE: begin
                busy = 1'b0;
                done = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/jrb_seq_chk.sv
module jrb_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic tms,
    input logic rb_valid,
    input logic rb_partial
);
    // R1
    idle_tms_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tms);

    // R2
    run_opens_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !tms);

    // R9
    busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R7
    valid_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rb_valid |-> busy);

    // R7
    partial_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rb_partial |-> rb_valid);
endmodule

bind jrb_seq jrb_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .tms        (tms),
    .rb_valid   (rb_valid),
    .rb_partial (rb_partial)
);

// File: tb/jrb_seq_bench.sv
module jrb_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int RB_W       = 16;

    localparam int T_TLR = 0,  T_RTI = 1,  T_SDR = 2,  T_CDR = 3;
    localparam int T_SHDR = 4, T_E1DR = 5, T_PDR = 6,  T_E2DR = 7;
    localparam int T_UDR = 8,  T_SIR = 9,  T_CIR = 10, T_SHIR = 11;
    localparam int T_E1IR = 12, T_PIR = 13, T_E2IR = 14, T_UIR = 15;

    localparam logic [9:0] WR_OP = 10'b1111000101;
    localparam logic [9:0] RD_OP = 10'b1111000100;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, tdo = 1'b0;
    logic [RB_W-1:0] rb_bits = '0;
    logic busy, done, tms, tdi, rb_valid, rb_partial;
    logic [31:0] rb_word;

    int checks = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    jrb_seq #(.RTI_CYCLES(12), .RB_W(RB_W)) u_jrb_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .rb_bits(rb_bits),
        .busy(busy), .done(done), .tms(tms), .tdi(tdi), .tdo(tdo),
        .rb_word(rb_word), .rb_valid(rb_valid), .rb_partial(rb_partial)
    );

    // ---------------- TAP model ----------------
    int         tap = T_TLR;
    logic       tms_s = 1'b1, tdi_s = 1'b0;
    logic [9:0] ir_sh = '0, ir_cur = '0;
    int         ir_cnt = 0, nloads = 0;
    logic [9:0] load_val [0:7];
    int         load_len [0:7];
    logic       cmd_bits [0:511];
    int         cmd_cnt = 0, rb_idx = 0, rti_zero = 0, key = 0, pc = 0;
    logic       seen_sel = 1'b0;
    logic [31:0] got_w [0:63];
    logic        got_p [0:63];
    int          ng = 0;

    function automatic int tap_next(input int s, input logic m);
        case (s)
            T_TLR:  return m ? T_TLR  : T_RTI;
            T_RTI:  return m ? T_SDR  : T_RTI;
            T_SDR:  return m ? T_SIR  : T_CDR;
            T_CDR:  return m ? T_E1DR : T_SHDR;
            T_SHDR: return m ? T_E1DR : T_SHDR;
            T_E1DR: return m ? T_UDR  : T_PDR;
            T_PDR:  return m ? T_E2DR : T_PDR;
            T_E2DR: return m ? T_UDR  : T_SHDR;
            T_UDR:  return m ? T_SDR  : T_RTI;
            T_SIR:  return m ? T_TLR  : T_CIR;
            T_CIR:  return m ? T_E1IR : T_SHIR;
            T_SHIR: return m ? T_E1IR : T_SHIR;
            T_E1IR: return m ? T_UIR  : T_PIR;
            T_PIR:  return m ? T_E2IR : T_PIR;
            T_E2IR: return m ? T_UIR  : T_SHIR;
            default: return m ? T_SDR : T_RTI;
        endcase
    endfunction

    function automatic logic pat(input int i, input int k);
        return logic'(((i * 13 + k) % 7) < 3) ^ logic'((i >> 4) & 1);
    endfunction

    function automatic logic [31:0] exp_pkt(input int w);
        case (w)
            0: return 32'hFFFFFFFF;  1: return 32'hAA995566;
            2: return 32'h20000000;  3: return 32'h30008001;
            4: return 32'h00000004;  5: return 32'h30002001;
            6: return 32'h00000000;  7: return 32'h28006000;
            8: return 32'h48024090;  9: return 32'h20000000;
            10: return 32'h20000000;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] exp_word(input int j, input int n, input int k);
        logic [31:0] w = '0;
        for (int b = 0; b < 32; b++)
            if (32 * j + b < n) w[31 - b] = pat(32 * j + b, k);
        return w;
    endfunction

    always @(posedge clk) begin
        pc <= pc + 1;
        case (tap)
            T_CIR:  ir_cnt = 0;
            T_SHIR: begin ir_sh = {tdi_s, ir_sh[9:1]}; ir_cnt++; end
            T_UIR: begin
                if (nloads < 8) begin
                    load_val[nloads] = ir_sh;
                    load_len[nloads] = ir_cnt;
                end
                nloads++;
                ir_cur = ir_sh;
            end
            T_SHDR: begin
                if (ir_cur == WR_OP) begin
                    if (cmd_cnt < 512) cmd_bits[cmd_cnt] = tdi_s;
                    cmd_cnt++;
                end else if (ir_cur == RD_OP) begin
                    rb_idx++;
                end
            end
            default: ;
        endcase
        if (!seen_sel && (tap == T_TLR || tap == T_RTI) && !tms_s) rti_zero++;
        if (tap == T_RTI && tms_s) seen_sel = 1'b1;
        tap = tap_next(tap, tms_s);
        if (tap == T_TLR) ir_cur = '0;
    end

    always @(negedge clk) begin
        tdo   <= (tap == T_SHDR && ir_cur == RD_OP) ? pat(rb_idx, key) : 1'b0;
        tms_s <= tms;
        tdi_s <= tdi;
        if (rb_valid) begin
            if (ng < 64) begin
                got_w[ng] = rb_word;
                got_p[ng] = rb_partial;
            end
            ng++;
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input logic ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_seq(input int n_req, input int k);
        int n, s, cyc, nw;
        logic busy_bad, hit_done;
        logic bits_ok;
        n = (n_req == 0) ? 1 : n_req;
        @(negedge clk);
        nloads = 0; cmd_cnt = 0; rb_idx = 0; rti_zero = 0;
        seen_sel = 1'b0; ng = 0; key = k;
        rb_bits = RB_W'(n_req);
        start = 1'b1;
        s = pc;
        busy_bad = 1'b0;
        hit_done = 1'b0;
        cyc = 0;
        while (!hit_done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            start = (cyc == 50);   // mid-run request, must be ignored (R9)
            if (done) hit_done = 1'b1;
            else if (!busy) busy_bad = 1'b1;
        end
        start = 1'b0;
        chk(hit_done, "R8", "done reached", longint'(hit_done), 1);
        if (!hit_done) return;
        chk(pc - s == 412 + n, "R5", "run length", pc - s, 412 + n);
        chk(tap == T_TLR, "R8", "TAP state at done", tap, T_TLR);
        chk(!busy, "R8", "busy at done", longint'(busy), 0);
        chk(rti_zero == 12, "R2", "idle TMS=0 cycles", rti_zero, 12);
        chk(load_val[0] == WR_OP && load_len[0] == 10, "R3", "write insn",
            load_val[0], WR_OP);
        chk(load_val[1] == RD_OP && load_len[1] == 10, "R3", "read insn",
            load_val[1], RD_OP);
        chk(cmd_cnt == 352, "R4", "packet bit count", cmd_cnt, 352);
        bits_ok = 1'b1;
        for (int i = 0; i < 352; i++) begin
            logic [31:0] w = exp_pkt(i / 32);
            if (i < cmd_cnt && cmd_bits[i] !== w[31 - (i % 32)]) bits_ok = 1'b0;
        end
        chk(bits_ok, "R4", "packet bits", longint'(bits_ok), 1);
        chk(rb_idx == n, "R6", "readback shift length", rb_idx, n);
        nw = (n + 31) / 32;
        chk(ng == nw, "R7", "word count", ng, nw);
        for (int j = 0; j < nw && j < ng && j < 64; j++) begin
            chk(got_w[j] == exp_word(j, n, k), "R7", "packed word",
                got_w[j], exp_word(j, n, k));
            chk(got_p[j] == ((j == nw - 1) && (n % 32 != 0)), "R7", "partial flag",
                longint'(got_p[j]), longint'((j == nw - 1) && (n % 32 != 0)));
        end
        @(negedge clk);
        chk(!done, "R8", "done width", longint'(done), 0);
        repeat (4) @(negedge clk);
        chk(!busy_bad, "R9", "busy held through run", longint'(busy_bad), 0);
        chk(!busy && nloads == 3, "R9", "no restart from ignored start", nloads, 3);
        chk(tms && !tdi && tap == T_TLR, "R1", "idle pins after run", tap, T_TLR);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk(tms == 1'b1 && tdi == 1'b0, "R1", "pins in reset", {tms, tdi}, 2'b10);
        chk(!busy && !done && !rb_valid, "R1", "status in reset",
            {busy, done, rb_valid}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && tms, "R1", "idle after reset", {busy, tms}, 2'b01);
        run_seq(1, 3);
        run_seq(0, 5);     // R10: zero request means one bit
        run_seq(32, 1);
        run_seq(33, 2);
        run_seq(64, 4);
        for (int r = 0; r < 4; r++)
            run_seq(int'($urandom_range(1, 300)), int'($urandom_range(0, 6)));
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule